// File: doc/BRIEF.md
# Paired-Bit Interrupt Status and Control Register

This block is a single 16-bit control and status word that sits between a host processor and an attached coprocessor. It collects three interrupt sources (the coprocessor itself, the auxiliary-memory DMA engine and the audio DMA engine). Each source owns a pending flag and an enable flag. The two share a pair of adjacent bit positions, with the enable flag always one bit above its pending flag. The block drives one level-sensitive interrupt line to the host. The line is high whenever some pending flag is set and the enable flag directly above it is also set.

The low bits of the same word hold four coprocessor control bits: reset, assert-interrupt, halt and init. The host writes these directly. A read-only busy bit mirrors a DMA-busy input. The bits above the busy bit are padding. They always read as zero. A write that puts ones into them raises a one-cycle error flag. Pending flags are set by one-cycle pulses from the sources. The host clears a pending flag by writing a one to it. If a source pulse and a host clear hit the same flag in the same cycle, the flag stays set.

Top module: `irq_pair_reg`

## Requirements
- R1: After reset the register reads 0x0004: only the halt bit (bit 2) is set. The interrupt output and the padding-error output are low.
- R2: A write stores bits 0 to 3 (bit 0 coprocessor reset, bit 1 assert-interrupt, bit 2 halt, bit 3 init) and the enable bits 5, 7 and 9 directly from the write data, starting on the cycle after the write.
- R3: Writing 1 to a pending bit clears it. The pending bits are bit 4 (coprocessor), bit 6 (auxiliary DMA) and bit 8 (audio DMA). Writing 0 to a pending bit leaves it unchanged.
- R4: A pulse on source input i (bit 0 coprocessor, bit 1 auxiliary DMA, bit 2 audio DMA) sets pending bit 4+2*i on the next cycle. Only these three pending positions can be set by a source.
- R5: When a source pulse and a write-1-to-clear target the same pending bit in the same cycle, the pending bit is set afterwards.
- R6: The interrupt output is high exactly when, for some source, both its pending bit and the enable bit one position above it are set. The output follows the stored register in the same cycle, with no extra delay.
- R7: Bit 10 of the read data always equals the DMA-busy input. Writes to bit 10 have no effect.
- R8: Bits 11 to 15 always read as zero. A write with any of them set raises the padding-error output for exactly the following cycle. A write with them all clear leaves the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Current register value |
| src_set | input | 3 | Per-source pending-set pulses |
| dma_busy | input | 1 | DMA busy status, mirrored to bit 10 |
| host_irq | output | 1 | Level interrupt to the host |
| pad_err | output | 1 | One-cycle flag for a write with nonzero padding bits |

## Verification
The bench targets a source pulse and a write-1-to-clear landing on the same flag in one cycle. A design that let the clear win would lose that event, and the flag would read 0. It checks that writing 0 to a pending bit leaves it alone. A design that stored pending bits like ordinary data would drop pending events on any unrelated write. It also checks each source paired with the enable of a neighbouring source. An off-by-one pairing would raise the interrupt for a masked source or miss an enabled one. Finally, the bench writes ones into the busy and padding positions. A design that stored them would read back nonzero padding or a busy value that does not follow the input.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;

    localparam int REG_W     = 16;
    localparam int CTRL_W    = 4;
    localparam int NUM_SRC   = 3;
    localparam int PEND_BASE = CTRL_W;
    localparam int BUSY_POS  = PEND_BASE + 2 * NUM_SRC;
    localparam int PAD_LO    = BUSY_POS + 1;
    localparam int PAD_W     = REG_W - PAD_LO;

    localparam logic [CTRL_W-1:0] CTRL_RESET_VAL = 4'b0100;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              pad_err;
    } ctl_state_t;

    typedef struct packed {
        logic pend;
        logic mask;
    } pair_state_t;

endpackage

// File: rtl/irq_pair_cell.sv
module irq_pair_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_en,
    input  logic wr_pend,
    input  logic wr_mask,
    output logic pend_q,
    output logic mask_q
);
    import irq_pair_pkg::*;

    pair_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mask = wr_mask;
            if (wr_pend) st_d.pend = 1'b0;
        end
        if (set_i) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;
    assign mask_q = st_q.mask;

    a_r4_set_pends: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_q);
    a_r3_clear_w1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_pend && !set_i) |=> !pend_q);
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !(wr_en && wr_pend)) |=> $stable(pend_q));
    a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask_q == $past(wr_mask)));
endmodule

// File: rtl/irq_pair_ctl.sv
module irq_pair_ctl (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [irq_pair_pkg::CTRL_W-1:0] wr_ctrl,
    input  logic [irq_pair_pkg::PAD_W-1:0]  wr_pad,
    output logic [irq_pair_pkg::CTRL_W-1:0] ctrl_q,
    output logic                         pad_err_q
);
    import irq_pair_pkg::*;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pad_err = wr_en && (wr_pad != '0);
        if (wr_en) st_d.ctrl = wr_ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl    <= CTRL_RESET_VAL;
            st_q.pad_err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q    = st_q.ctrl;
    assign pad_err_q = st_q.pad_err;

    a_r8_pad_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pad_err_q |-> $past(wr_en));
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/irq_pair_reg.sv
module irq_pair_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic [2:0]  src_set,
    input  logic        dma_busy,
    output logic        host_irq,
    output logic        pad_err
);
    import irq_pair_pkg::*;

    logic [CTRL_W-1:0]  ctrl_q;
    logic [NUM_SRC-1:0] pend_q, mask_q;
    logic [REG_W-1:0]   word;
    logic [REG_W-1:0]   pend_sel;

    irq_pair_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ctrl  (wr_data[CTRL_W-1:0]),
        .wr_pad   (wr_data[REG_W-1:PAD_LO]),
        .ctrl_q   (ctrl_q),
        .pad_err_q(pad_err)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_pair_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (src_set[i]),
            .wr_en  (wr_en),
            .wr_pend(wr_data[PEND_BASE + 2*i]),
            .wr_mask(wr_data[PEND_BASE + 2*i + 1]),
            .pend_q (pend_q[i]),
            .mask_q (mask_q[i])
        );
    end

    always_comb begin
        word = '0;
        word[CTRL_W-1:0] = ctrl_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            word[PEND_BASE + 2*i]     = pend_q[i];
            word[PEND_BASE + 2*i + 1] = mask_q[i];
        end
        word[BUSY_POS] = dma_busy;
    end

    always_comb begin
        pend_sel = '0;
        for (int i = 0; i < NUM_SRC; i++) pend_sel[PEND_BASE + 2*i] = 1'b1;
    end

    assign rd_data  = word;
    assign host_irq = |((word >> 1) & word & pend_sel);

    a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:PAD_LO] == '0);
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> ((pend_q & mask_q) != '0));
    a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> $past(wr_en || (src_set != '0)));
endmodule

// File: tb/irq_pair_reg_test.sv
module irq_pair_reg_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [2:0]  src_set = '0;
    logic        dma_busy = 0;
    logic        host_irq;
    logic        pad_err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] m_reg;
    logic        m_pad;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pair_reg uut (.*);

    function automatic logic [15:0] next_reg(logic [15:0] r, logic w,
                                             logic [15:0] d, logic [2:0] s);
        logic [15:0] n = r;
        if (w) begin
            n[3:0] = d[3:0];
            n[5] = d[5]; n[7] = d[7]; n[9] = d[9];
            if (d[4]) n[4] = 0;
            if (d[6]) n[6] = 0;
            if (d[8]) n[8] = 0;
        end
        if (s[0]) n[4] = 1;
        if (s[1]) n[6] = 1;
        if (s[2]) n[8] = 1;
        n[15:10] = '0;
        return n;
    endfunction

    function automatic logic exp_irq(logic [15:0] r);
        return (r[4] & r[5]) | (r[6] & r[7]) | (r[8] & r[9]);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        logic [15:0] e = m_reg;
        e[10] = dma_busy;
        check({req, " R7 R8 rd_data"}, rd_data, e);
        check({req, " R6 host_irq"}, {15'd0, host_irq}, {15'd0, exp_irq(m_reg)});
        check({req, " R8 pad_err"}, {15'd0, pad_err}, {15'd0, m_pad});
    endtask

    task automatic step(logic w, logic [15:0] d, logic [2:0] s, logic b, string req);
        wr_en = w; wr_data = d; src_set = s; dma_busy = b;
        @(posedge clk);
        m_reg = next_reg(m_reg, w, d, s);
        m_pad = w && (d[15:11] != 0);
        @(negedge clk);
        wr_en = 0; src_set = 0;
        check_all(req);
    endtask

    initial begin
        fork
            begin
                void'($urandom(32'h5eed));
                m_reg = 16'h0004; m_pad = 0;
                #(3*CLK_PERIOD);
                @(negedge clk);
                rst_n = 1;
                check_all("R1 reset");
                // R2: direct control and mask write
                step(1, 16'h02AB, 0, 0, "R2 ctrl/mask write");
                step(1, 16'h0000, 0, 0, "R2 clear ctrl");
                // R4: each source sets its own pending bit only
                step(0, 0, 3'b001, 0, "R4 src0");
                step(0, 0, 3'b100, 0, "R4 src2");
                // R3: write 0 keeps pending, write 1 clears
                step(1, 16'h0000, 0, 0, "R3 zero keeps");
                step(1, 16'h0010, 0, 0, "R3 w1c src0");
                // R6: neighbour mask must not enable
                step(1, 16'h0020, 0, 0, "R6 mask0 only");
                step(0, 0, 3'b010, 0, "R6 src1 masked off");
                step(1, 16'h00A0, 0, 0, "R6 mask1 on");
                // R5: set beats clear
                step(1, 16'h0040, 3'b010, 0, "R5 set wins");
                // R7: busy read-only
                step(1, 16'h0400, 0, 1, "R7 busy write ignored");
                step(0, 0, 0, 0, "R7 busy follows input");
                // R8: padding
                step(1, 16'h8000, 0, 0, "R8 pad error");
                step(0, 0, 0, 0, "R8 pad one cycle");
                step(1, 16'h07FF, 0, 0, "R8 no pad error");
                for (int k = 0; k < 400; k++) begin
                    logic [15:0] d = 16'($urandom);
                    if ($urandom % 4 != 0) d[15:11] = 0;
                    step(($urandom % 2) == 1, d, 3'($urandom), 1'($urandom), "R2 R3 R4 R5 random");
                end
            end
            begin
                #(200000 * CLK_PERIOD);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule